// File: doc/BRIEF.md
# Fractional UART Baud Generator

This block derives the oversampling strobe for a UART receiver and transmitter from a divided peripheral clock. A 16-bit integer divisor first sets a base unit of twice that divisor in clocks. A multiplier made of an integer part of 1 to 3 and an eleven-bit fraction in 2048ths then stretches the sample period to a non-integer number of base units. The fraction works like a phase accumulator: each sample period it adds the fraction. Whenever the addition wraps, that period runs one base unit longer. Over 2048 periods the extensions add up to exactly the fraction, so the mean period matches the ideal rate.

Two single-cycle strobes leave the block. One is the sample strobe, at sixteen times the bit rate. The other is the bit strobe, which marks every sixteenth sample strobe. Software picks the divisor and multiplier for the current peripheral clock. If that clock changes, new values must be written; the block does not adjust itself. Configuration is expected to change only while reset is held.

Top module: `frac_baud_gen`

## Requirements
- R1: A base unit lasts 2 × D clocks, where D is the 16-bit divisor field and a field value of 0 stands for D = 65536.
- R2: The sample strobe is high for exactly one cycle per sample period, and two sample strobes are never in adjacent cycles.
- R3: Sample period k lasts 2 × D × (M + c_k) clocks. Here c_k is the carry out of bit 11 when the fraction N is added to an 11-bit accumulator. The accumulator starts at 0 after reset and keeps the low 11 bits of each sum.
- R4: Over 2048 consecutive sample periods from reset, the total length is 2 × D × (2048 × M + N) clocks, within one clock.
- R5: The bit strobe goes high in the same cycle as every 16th sample strobe, and never without a sample strobe.
- R6: While reset is held, both strobes are low. The first sample strobe appears 2 × D × M clocks after the first clock edge with reset low, because the first addition cannot carry.
- R7: A multiplier integer field of 0 is treated as 1.
- R8: With N = 0 every sample period has the same length, 2 × D × M clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided peripheral clock |
| rst | input | 1 | Synchronous reset, active high |
| div_i | input | 16 | Integer divisor D (0 means 65536) |
| mult_i | input | 2 | Integer part M of the multiplier (0 treated as 1) |
| frac_i | input | 11 | Fractional part N of the multiplier, in 2048ths |
| sample_tick | output | 1 | One-cycle strobe at 16× the bit rate |
| bit_tick | output | 1 | One-cycle strobe at the bit rate, coincident with a sample strobe |

## Verification
Two events can land on the same sample strobe: a period stretched by an accumulator carry, and the sixteenth-sample boundary that raises the bit strobe. The bench provokes this with fractions of 1000 and 2047. With those values carries fall on many multiples of sixteen. The scoreboard predicts each period's length and bit flag from a model of the accumulator written on its own, and compares both at every sample strobe. Over a full 2048-period run, the summed gaps are also checked against the closed-form total.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;
   parameter int unsigned FBG_DIV_W   = 16;
   parameter int unsigned FBG_MULT_W  = 2;
   parameter int unsigned FBG_FRAC_W  = 11;
   parameter int unsigned FBG_OVERSMP = 16;

   // Map a zero multiplier to one; other values pass through.
   function automatic logic [FBG_MULT_W-1:0] mult_floor(input logic [FBG_MULT_W-1:0] m);
      return (m == '0) ? FBG_MULT_W'(1) : m;
   endfunction
endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
   parameter int unsigned DIV_W = 16,
   localparam int unsigned PRE_W = DIV_W + 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [DIV_W-1:0] div,
   output logic [PRE_W-1:0] cnt,
   output logic [PRE_W-1:0] limit,
   output logic             unit_pulse
);
   logic div_zero;

   assign div_zero   = (div == '0);
   // 2 x D, with a zero field standing for 2^DIV_W
   assign limit      = {div_zero, div, 1'b0};
   assign unit_pulse = (cnt >= limit - PRE_W'(1));

   always_ff @(posedge clk) begin
      if (rst)             cnt <= '0;
      else if (unit_pulse) cnt <= '0;
      else                 cnt <= cnt + PRE_W'(1);
   end
endmodule

// File: rtl/baud_frac_stage.sv
module baud_frac_stage
   import frac_baud_pkg::*;
#(
   parameter int unsigned MULT_W = 2,
   parameter int unsigned FRAC_W = 11,
   localparam int unsigned UNIT_W = MULT_W + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              unit_pulse,
   input  logic [MULT_W-1:0] mult,
   input  logic [FRAC_W-1:0] frac,
   output logic              samp_evt,
   output logic [FRAC_W-1:0] acc
);
   logic [FRAC_W:0]   sum;
   logic [UNIT_W-1:0] target;
   logic [UNIT_W-1:0] unit_cnt;
   logic [MULT_W-1:0] m_eff;

   assign m_eff    = (mult == '0) ? MULT_W'(1) : mult;
   assign sum      = {1'b0, acc} + {1'b0, frac};
   assign target   = UNIT_W'(m_eff) + UNIT_W'(sum[FRAC_W]);
   assign samp_evt = unit_pulse && (unit_cnt >= target - UNIT_W'(1));

   always_ff @(posedge clk) begin
      if (rst) begin
         unit_cnt <= '0;
         acc      <= '0;
      end else if (unit_pulse) begin
         if (samp_evt) begin
            unit_cnt <= '0;
            acc      <= sum[FRAC_W-1:0];
         end else begin
            unit_cnt <= unit_cnt + UNIT_W'(1);
         end
      end
   end
endmodule

// File: rtl/baud_bit_stage.sv
module baud_bit_stage #(
   parameter int unsigned OVERSAMPLE = 16,
   localparam int unsigned CW = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1
) (
   input  logic clk,
   input  logic rst,
   input  logic samp_evt,
   output logic bit_evt
);
   logic [CW-1:0] cnt;
   logic          last;

   generate
      if ((OVERSAMPLE & (OVERSAMPLE - 1)) == 0) begin : g_pow2
         assign last = &cnt;
         always_ff @(posedge clk) begin
            if (rst)           cnt <= '0;
            else if (samp_evt) cnt <= cnt + CW'(1);
         end
      end else begin : g_mod
         assign last = (cnt == CW'(OVERSAMPLE - 1));
         always_ff @(posedge clk) begin
            if (rst)           cnt <= '0;
            else if (samp_evt) cnt <= last ? '0 : cnt + CW'(1);
         end
      end
   endgenerate

   assign bit_evt = samp_evt && last;
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
   import frac_baud_pkg::*;
#(
   parameter int unsigned DIV_W      = FBG_DIV_W,
   parameter int unsigned MULT_W     = FBG_MULT_W,
   parameter int unsigned FRAC_W     = FBG_FRAC_W,
   parameter int unsigned OVERSAMPLE = FBG_OVERSMP,
   localparam int unsigned PRE_W     = DIV_W + 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DIV_W-1:0]  div_i,
   input  logic [MULT_W-1:0] mult_i,
   input  logic [FRAC_W-1:0] frac_i,
   output logic              sample_tick,
   output logic              bit_tick
);
   generate
      if (DIV_W < 1 || DIV_W > 30) begin : g_bad_div
         $error("frac_baud_gen: DIV_W out of range");
      end
      if (MULT_W < 1) begin : g_bad_mult
         $error("frac_baud_gen: MULT_W must be at least 1");
      end
      if (FRAC_W < 1) begin : g_bad_frac
         $error("frac_baud_gen: FRAC_W must be at least 1");
      end
      if (OVERSAMPLE < 2) begin : g_bad_os
         $error("frac_baud_gen: OVERSAMPLE must be at least 2");
      end
   endgenerate

   logic [PRE_W-1:0]  pre_cnt;
   logic [PRE_W-1:0]  pre_limit;
   logic              unit_pulse;
   logic              samp_evt;
   logic              bit_evt;
   logic [FRAC_W-1:0] frac_acc;

   baud_prescaler #(.DIV_W(DIV_W)) u_pre (
      .clk        (clk),
      .rst        (rst),
      .div        (div_i),
      .cnt        (pre_cnt),
      .limit      (pre_limit),
      .unit_pulse (unit_pulse)
   );

   baud_frac_stage #(.MULT_W(MULT_W), .FRAC_W(FRAC_W)) u_frac (
      .clk        (clk),
      .rst        (rst),
      .unit_pulse (unit_pulse),
      .mult       (mult_i),
      .frac       (frac_i),
      .samp_evt   (samp_evt),
      .acc        (frac_acc)
   );

   baud_bit_stage #(.OVERSAMPLE(OVERSAMPLE)) u_bit (
      .clk      (clk),
      .rst      (rst),
      .samp_evt (samp_evt),
      .bit_evt  (bit_evt)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         sample_tick <= 1'b0;
         bit_tick    <= 1'b0;
      end else begin
         sample_tick <= samp_evt;
         bit_tick    <= bit_evt;
      end
   end
endmodule

// File: rtl/frac_baud_gen_chk.sv
module frac_baud_gen_chk #(
   parameter int unsigned OVERSAMPLE = 16,
   parameter int unsigned FRAC_W     = 11,
   localparam int unsigned CW        = $clog2(OVERSAMPLE) + 1
) (
   input logic              clk,
   input logic              rst,
   input logic              sample_tick,
   input logic              bit_tick,
   input logic              samp_evt,
   input logic [FRAC_W-1:0] acc
);
   logic [CW-1:0] since_bit;

   always_ff @(posedge clk) begin
      if (rst)              since_bit <= '0;
      else if (bit_tick)    since_bit <= '0;
      else if (sample_tick) since_bit <= since_bit + CW'(1);
   end

   a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
      sample_tick |=> !sample_tick);

   a_r3_acc_holds: assert property (@(posedge clk) disable iff (rst)
      !samp_evt |=> $stable(acc));

   a_r5_bit_needs_sample: assert property (@(posedge clk) disable iff (rst)
      bit_tick |-> sample_tick);

   a_r5_bit_spacing: assert property (@(posedge clk) disable iff (rst)
      bit_tick |-> (since_bit == CW'(OVERSAMPLE - 1)));

   a_r5_bit_not_missed: assert property (@(posedge clk) disable iff (rst)
      (sample_tick && since_bit == CW'(OVERSAMPLE - 1)) |-> bit_tick);

   a_r6_quiet_after_reset: assert property (@(posedge clk)
      $fell(rst) |-> (!sample_tick && !bit_tick));
endmodule

bind frac_baud_gen frac_baud_gen_chk #(.OVERSAMPLE(OVERSAMPLE), .FRAC_W(FRAC_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .sample_tick (sample_tick),
   .bit_tick    (bit_tick),
   .samp_evt    (samp_evt),
   .acc         (frac_acc)
);

// File: tb/frac_baud_gen_tb.sv
`timescale 1ns/1ps
module frac_baud_gen_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] div_i = 16'd1;
   logic [1:0]  mult_i = 2'd1;
   logic [10:0] frac_i = '0;
   logic        sample_tick;
   logic        bit_tick;

   typedef struct {
      int unsigned gap;
      bit          bflag;
   } exp_t;

   exp_t        exp_q[$];
   int          errors = 0;
   int          checks = 0;
   int unsigned gap = 0;
   longint unsigned gap_sum = 0;
   int unsigned tick_no = 0;

   always #5 clk = ~clk;

   frac_baud_gen u_dut (
      .clk(clk), .rst(rst), .div_i(div_i), .mult_i(mult_i), .frac_i(frac_i),
      .sample_tick(sample_tick), .bit_tick(bit_tick)
   );

   // monitor: measures gaps between sample strobes and scores them
   always @(negedge clk) begin
      if (rst) begin
         gap = 0;
      end else begin
         gap = gap + 1;
         if (!sample_tick && bit_tick) begin
            checks++; errors++;
            $display("FAIL R5: bit strobe without sample strobe, got bit=1 expected bit=0");
         end
         if (sample_tick) begin
            tick_no++;
            checks++;
            if (exp_q.size() == 0) begin
               errors++;
               $display("FAIL R2: unexpected sample strobe %0d, got gap=%0d expected none", tick_no, gap);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               // R3 R6 R8: period length
               if (gap != e.gap) begin
                  errors++;
                  $display("FAIL R3: strobe %0d gap got %0d expected %0d", tick_no, gap, e.gap);
               end
               checks++;
               // R5: bit strobe on every 16th sample
               if (bit_tick != e.bflag) begin
                  errors++;
                  $display("FAIL R5: strobe %0d bit got %0d expected %0d", tick_no, bit_tick, e.bflag);
               end
            end
            gap_sum = gap_sum + gap;
            gap = 0;
         end
      end
   end

   task automatic run_cfg(input int unsigned d_field, input int unsigned m, input int unsigned n,
                          input int unsigned periods, input bit avg_chk);
      int unsigned d_eff;
      int unsigned m_eff;
      int unsigned acc;
      longint unsigned want;
      rst    <= 1'b1;
      div_i  <= 16'(d_field);
      mult_i <= 2'(m);
      frac_i <= 11'(n);
      repeat (3) @(negedge clk);
      // R6: strobes low under reset
      checks++;
      if (sample_tick !== 1'b0 || bit_tick !== 1'b0) begin
         errors++;
         $display("FAIL R6: under reset got sample=%0b bit=%0b expected 0 0", sample_tick, bit_tick);
      end
      d_eff = (d_field == 0) ? 65536 : d_field;   // R1
      m_eff = (m == 0) ? 1 : m;                   // R7
      acc = 0;
      for (int k = 1; k <= int'(periods); k++) begin
         exp_t e;
         int unsigned s;
         s = acc + n;
         e.gap = 2 * d_eff * (m_eff + ((s >= 2048) ? 1 : 0));
         e.bflag = (k % 16 == 0);
         acc = s % 2048;
         exp_q.push_back(e);
      end
      gap_sum = 0;
      tick_no = 0;
      rst <= 1'b0;
      while (exp_q.size() != 0) @(negedge clk);
      if (avg_chk) begin
         // R4: total over 2048 periods
         want = longint'(2) * d_eff * (longint'(2048) * m_eff + n);
         checks++;
         if ((gap_sum > want + 1) || (gap_sum + 1 < want)) begin
            errors++;
            $display("FAIL R4: 2048-period total got %0d expected %0d", gap_sum, want);
         end
      end
   endtask

   initial begin
      run_cfg(1, 1, 0, 40, 1'b0);        // R8 uniform, R5 several bit strobes
      run_cfg(1, 2, 1000, 2048, 1'b1);   // R3 R4 carries, average
      run_cfg(3, 3, 2047, 64, 1'b0);     // R3 carry nearly every period
      run_cfg(5, 0, 512, 40, 1'b0);      // R7 zero multiplier
      run_cfg(0, 1, 0, 1, 1'b0);         // R1 zero divisor means 65536
      rst <= 1'b1;
      repeat (2) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (195000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule